// File: doc/BRIEF.md
# Nested Vectored Interrupt Priority Unit

This block sits behind the source-masking stage of an interrupt controller. It receives two 32-bit request vectors: the masked vector, which holds the requests that are enabled and routed to the normal interrupt path, and the raw vector, which holds every pending source. Sixteen vector slots each bind one source number to a handler address. Slot 0 has the highest priority. A seventeenth, unvectored level uses a shared default address.

A handler starts by reading the acknowledge word. The unit looks for the highest-priority level whose mask covers a pending source. It returns that level's handler address and makes that level current, so that only slots above it can raise the interrupt line again. It also records the level it replaced, one record per level. A write of any value to the same word ends the handler and restores the recorded level. Handlers can therefore nest to any depth the sixteen slots allow.

The interrupt output is the masked request vector ANDed with the mask of the current level. The mask of level i covers the sources of every enabled slot with an index below i. The idle level (17) lets every request through. Bus reads return their data one cycle after the read strobe. A fixed eight-byte identification block can be read back.

Top module: `vec_prio_unit`

## Requirements
- R1: After reset, all slot handler addresses, slot control bytes and the default address read as zero, and the current level is idle (17), so any masked request raises `irq`.
- R2: A slot's control byte uses bit 5 as the slot enable and bits 4:0 as the source number. A disabled slot contributes to no level mask.
- R3: `irq` equals the OR of (masked request AND mask of the current level). The mask of level i is the OR of the one-hot source bits of the enabled slots with index below i. Level 16 covers all enabled slots. The idle level's mask is all ones.
- R4: A read of word offset 0x030 scans levels 0 up to, but not including, the current level. It picks the first level whose mask hits the raw request vector. It records the old current level for that level, makes that level current, and returns that level's handler address. Level 16's handler address is the default address.
- R5: If that scan finds no level, the read returns the default address and the current level is unchanged.
- R6: A write to offset 0x030 ignores its data. If the current level is below 17, the current level becomes the level recorded for it. At idle the write has no effect.
- R7: Slot k's handler address is read/write at 0x100+4k. Its control byte is at 0x200+4k: only bits 7:0 are stored, and reads return them zero-extended. The default address is at 0x034. Read data appears on `bus_rdata` in the cycle after `bus_rd`.
- R8: Reads of 0xFE0+4i for i = 0..7 return the bytes 0x90, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order.
- R9: A write to a slot control byte changes the level masks, and so `irq`, from the cycle after the write.
- R10: Acknowledges nest. A second acknowledge at a higher priority records the first handler's level, and two end-of-handler writes return first to the first handler's level and then to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_masked | input | SRC_W | Enabled requests on the normal path |
| req_raw | input | SRC_W | All pending requests, unmasked |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after `bus_rd` |
| irq | output | 1 | Priority-qualified interrupt request |

## Verification
The assertions take two things for granted:
- `bus_rd` and `bus_wr` are never high in the same cycle.
- Each access is a single-cycle strobe on a word-aligned address.

Under these conditions, every change of the current level comes from an acknowledge read or an end-of-handler write. The bench keeps within them by driving every access through one read task or one write task. Each task raises exactly one strobe for one cycle on an aligned address, and the tasks change the request vectors only between accesses. Sixteen source numbers are spread over the slots as (5k+1) mod 32, which are all distinct. This lets the sweeps predict, for every slot, the level an acknowledge must land on.

// File: rtl/vpu_pkg.sv
package vpu_pkg;

    // Geometry of a slot control byte
    localparam int CTRL_W      = 8;
    localparam int CTRL_EN_BIT = 5;
    localparam int SRC_SEL_W   = 5;

    // Word indices (byte address / 4) of the register windows
    localparam int WIDX_ACK   = 'h00C;
    localparam int WIDX_DEF   = 'h00D;
    localparam int WIDX_VADDR = 'h040;
    localparam int WIDX_VCTRL = 'h080;
    localparam int WIDX_ID    = 'h3F8;
    localparam int ID_WORDS   = 8;

    typedef struct packed {
        logic                 en;
        logic [SRC_SEL_W-1:0] src;
    } slot_cfg_t;

    function automatic slot_cfg_t decode_ctrl(input logic [CTRL_W-1:0] raw);
        slot_cfg_t c;
        c.en  = raw[CTRL_EN_BIT];
        c.src = raw[SRC_SEL_W-1:0];
        return c;
    endfunction

    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        logic [7:0] b;
        case (idx)
            3'd0:    b = 8'h90;
            3'd1:    b = 8'h11;
            3'd2:    b = 8'h04;
            3'd3:    b = 8'h00;
            3'd4:    b = 8'h0D;
            3'd5:    b = 8'hF0;
            3'd6:    b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/vpu_slot_bank.sv
module vpu_slot_bank
    import vpu_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    parameter int DATA_W    = 32,
    parameter int WORD_W    = 10
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                wr_en,
    input  logic [WORD_W-1:0]                   wr_word,
    input  logic [DATA_W-1:0]                   wdata,
    output logic [NUM_SLOTS-1:0][DATA_W-1:0]    vaddr,
    output logic [NUM_SLOTS-1:0][CTRL_W-1:0]    vctrl,
    output logic [DATA_W-1:0]                   def_addr
);

    logic [DATA_W-1:0] def_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            def_q <= '0;
        end else if (wr_en && int'(wr_word) == WIDX_DEF) begin
            def_q <= wdata;
        end
    end

    assign def_addr = def_q;

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
        logic [DATA_W-1:0] va_q;
        logic [CTRL_W-1:0] vc_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                va_q <= '0;
            end else if (wr_en && int'(wr_word) == WIDX_VADDR + k) begin
                va_q <= wdata;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                vc_q <= '0;
            end else if (wr_en && int'(wr_word) == WIDX_VCTRL + k) begin
                vc_q <= wdata[CTRL_W-1:0];
            end
        end

        assign vaddr[k] = va_q;
        assign vctrl[k] = vc_q;
    end

endmodule

// File: rtl/vpu_mask_gen.sv
module vpu_mask_gen
    import vpu_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    parameter int SRC_W     = 32
) (
    input  logic [NUM_SLOTS-1:0][CTRL_W-1:0] vctrl,
    output logic [NUM_SLOTS+1:0][SRC_W-1:0]  lvl_mask
);

    logic [NUM_SLOTS-1:0][SRC_W-1:0] contrib;

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_contrib
        slot_cfg_t cfg;
        assign cfg        = decode_ctrl(vctrl[k]);
        assign contrib[k] = cfg.en ? ({{(SRC_W-1){1'b0}}, 1'b1} << cfg.src) : '0;
    end

    // Prefix OR: level i sees every enabled slot strictly above it.
    always_comb begin
        logic [SRC_W-1:0] acc;
        acc = '0;
        for (int k = 0; k < NUM_SLOTS; k++) begin
            lvl_mask[k] = acc;
            acc         = acc | contrib[k];
        end
        lvl_mask[NUM_SLOTS]   = acc;
        lvl_mask[NUM_SLOTS+1] = '1;
    end

endmodule

// File: rtl/vpu_nest_ctrl.sv
module vpu_nest_ctrl #(
    parameter int NUM_SLOTS = 16,
    parameter int SRC_W     = 32,
    parameter int LVL_W     = 5
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             ack,
    input  logic                             eoi,
    input  logic [SRC_W-1:0]                 req_raw,
    input  logic [NUM_SLOTS+1:0][SRC_W-1:0]  lvl_mask,
    output logic [LVL_W-1:0]                 cur_lvl,
    output logic                             hit,
    output logic [LVL_W-1:0]                 hit_lvl
);

    localparam int NUM_LVLS = NUM_SLOTS + 1;
    localparam logic [LVL_W-1:0] IDLE_LVL = LVL_W'(NUM_SLOTS + 1);

    logic [LVL_W-1:0] cur_q;
    logic [LVL_W-1:0] saved_q [NUM_LVLS];

    // First level below the current one whose mask meets a raw request
    always_comb begin
        hit     = 1'b0;
        hit_lvl = '0;
        for (int i = 0; i < NUM_LVLS; i++) begin
            if (!hit && (LVL_W'(i) < cur_q) && (|(req_raw & lvl_mask[i]))) begin
                hit     = 1'b1;
                hit_lvl = LVL_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= IDLE_LVL;
            for (int i = 0; i < NUM_LVLS; i++) begin
                saved_q[i] <= '0;
            end
        end else if (ack && hit) begin
            saved_q[hit_lvl] <= cur_q;
            cur_q            <= hit_lvl;
        end else if (eoi && cur_q != IDLE_LVL) begin
            cur_q <= saved_q[cur_q];
        end
    end

    assign cur_lvl = cur_q;

endmodule

// File: rtl/vec_prio_unit.sv
module vec_prio_unit
    import vpu_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    parameter int SRC_W     = 32,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SRC_W-1:0]  req_masked,
    input  logic [SRC_W-1:0]  req_raw,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    localparam int LVL_W   = $clog2(NUM_SLOTS + 2);
    localparam int SLOT_IW = $clog2(NUM_SLOTS);
    localparam int WORD_W  = ADDR_W - 2;

    logic [WORD_W-1:0]                 word;
    int                                widx;
    logic                              ack;
    logic                              eoi;
    logic [NUM_SLOTS-1:0][DATA_W-1:0]  vaddr;
    logic [NUM_SLOTS-1:0][CTRL_W-1:0]  vctrl;
    logic [DATA_W-1:0]                 def_addr;
    logic [NUM_SLOTS+1:0][SRC_W-1:0]   lvl_mask;
    logic [LVL_W-1:0]                  cur_lvl;
    logic                              hit;
    logic [LVL_W-1:0]                  hit_lvl;
    logic [DATA_W-1:0]                 rd_next;
    logic [DATA_W-1:0]                 rdata_q;

    assign word = bus_addr[ADDR_W-1:2];
    assign widx = int'(word);
    assign ack  = bus_rd && widx == WIDX_ACK;
    assign eoi  = bus_wr && widx == WIDX_ACK;

    vpu_slot_bank #(
        .NUM_SLOTS (NUM_SLOTS),
        .DATA_W    (DATA_W),
        .WORD_W    (WORD_W)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_wr),
        .wr_word  (word),
        .wdata    (bus_wdata),
        .vaddr    (vaddr),
        .vctrl    (vctrl),
        .def_addr (def_addr)
    );

    vpu_mask_gen #(
        .NUM_SLOTS (NUM_SLOTS),
        .SRC_W     (SRC_W)
    ) u_mask (
        .vctrl    (vctrl),
        .lvl_mask (lvl_mask)
    );

    vpu_nest_ctrl #(
        .NUM_SLOTS (NUM_SLOTS),
        .SRC_W     (SRC_W),
        .LVL_W     (LVL_W)
    ) u_nest (
        .clk      (clk),
        .rst      (rst),
        .ack      (ack),
        .eoi      (eoi),
        .req_raw  (req_raw),
        .lvl_mask (lvl_mask),
        .cur_lvl  (cur_lvl),
        .hit      (hit),
        .hit_lvl  (hit_lvl)
    );

    function automatic logic [DATA_W-1:0] level_addr(input logic [LVL_W-1:0] lvl);
        if (int'(lvl) < NUM_SLOTS) begin
            return vaddr[SLOT_IW'(lvl)];
        end
        return def_addr;
    endfunction

    always_comb begin
        rd_next = '0;
        if (widx == WIDX_ACK) begin
            rd_next = hit ? level_addr(hit_lvl) : def_addr;
        end else if (widx == WIDX_DEF) begin
            rd_next = def_addr;
        end else if (widx >= WIDX_VADDR && widx < WIDX_VADDR + NUM_SLOTS) begin
            rd_next = vaddr[SLOT_IW'(widx - WIDX_VADDR)];
        end else if (widx >= WIDX_VCTRL && widx < WIDX_VCTRL + NUM_SLOTS) begin
            rd_next = DATA_W'(vctrl[SLOT_IW'(widx - WIDX_VCTRL)]);
        end else if (widx >= WIDX_ID && widx < WIDX_ID + ID_WORDS) begin
            rd_next = DATA_W'(id_byte(3'(widx - WIDX_ID)));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (bus_rd) begin
            rdata_q <= rd_next;
        end
    end

    assign bus_rdata = rdata_q;
    assign irq       = |(req_masked & lvl_mask[cur_lvl]);

endmodule

// File: rtl/vpu_checker.sv
module vpu_checker #(
    parameter int NUM_SLOTS = 16,
    parameter int SRC_W     = 32,
    parameter int ADDR_W    = 12,
    parameter int LVL_W     = 5
) (
    input logic              clk,
    input logic              rst,
    input logic [SRC_W-1:0]  req_masked,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              irq,
    input logic [LVL_W-1:0]  cur_lvl,
    input logic              hit
);

    localparam logic [LVL_W-1:0] IDLE_LVL = LVL_W'(NUM_SLOTS + 1);

    logic ack_c;
    logic eoi_c;

    assign ack_c = bus_rd && int'(bus_addr[ADDR_W-1:2]) == vpu_pkg::WIDX_ACK;
    assign eoi_c = bus_wr && int'(bus_addr[ADDR_W-1:2]) == vpu_pkg::WIDX_ACK;

    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> cur_lvl == IDLE_LVL); // R1
    AST_IRQ_IDLE_PASS: assert property (@(posedge clk) disable iff (rst) cur_lvl == IDLE_LVL |-> irq == (|req_masked)); // R3
    AST_IRQ_TOP_SILENT: assert property (@(posedge clk) disable iff (rst) cur_lvl == '0 |-> !irq); // R3
    AST_LVL_IN_RANGE: assert property (@(posedge clk) disable iff (rst) cur_lvl <= IDLE_LVL); // R4
    AST_ACK_NEVER_LOWERS: assert property (@(posedge clk) disable iff (rst) ack_c |=> cur_lvl <= $past(cur_lvl)); // R4
    AST_NOHIT_HOLDS: assert property (@(posedge clk) disable iff (rst) ack_c && !hit |=> cur_lvl == $past(cur_lvl)); // R5
    AST_EOI_IDLE_STAYS: assert property (@(posedge clk) disable iff (rst) eoi_c && cur_lvl == IDLE_LVL |=> cur_lvl == IDLE_LVL); // R6
    AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (rst) !ack_c && !eoi_c |=> $stable(cur_lvl)); // R10

endmodule

bind vec_prio_unit vpu_checker #(
    .NUM_SLOTS (NUM_SLOTS),
    .SRC_W     (SRC_W),
    .ADDR_W    (ADDR_W),
    .LVL_W     (LVL_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_masked (req_masked),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .irq        (irq),
    .cur_lvl    (cur_lvl),
    .hit        (hit)
);

// File: tb/vec_prio_unit_bench.sv
module vec_prio_unit_bench;

    localparam logic [11:0] A_ACK = 12'h030;
    localparam logic [11:0] A_DEF = 12'h034;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] req_masked = '0;
    logic [31:0] req_raw = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;

    // Reference state derived from the requirements
    logic [7:0]  m_ctrl  [16];
    logic [31:0] m_vaddr [16];
    logic [31:0] m_def;
    int          m_cur;
    int          m_saved [17];

    always #4 clk = ~clk;

    vec_prio_unit u_vec_prio_unit (
        .clk        (clk),
        .rst        (rst),
        .req_masked (req_masked),
        .req_raw    (req_raw),
        .bus_rd     (bus_rd),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq        (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic set_req(input logic [31:0] v);
        @(negedge clk);
        req_raw = v; req_masked = v;
        #1;
    endtask

    function automatic logic [4:0] src_of(input int k);
        return 5'((5 * k + 1) % 32);
    endfunction

    function automatic logic [31:0] mdl_mask(input int lvl);
        logic [31:0] acc;
        if (lvl >= 17) return '1;
        acc = '0;
        for (int j = 0; j < lvl && j < 16; j++) begin
            if (m_ctrl[j][5]) acc = acc | (32'd1 << m_ctrl[j][4:0]);
        end
        return acc;
    endfunction

    function automatic logic [31:0] mdl_addr(input int lvl);
        return (lvl < 16) ? m_vaddr[lvl] : m_def;
    endfunction

    task automatic write_ctrl(input int k, input logic [31:0] d);
        m_ctrl[k] = d[7:0];
        bus_write(12'h200 + 12'(4 * k), d);
    endtask

    task automatic ack_check(input string tag);
        int          found;
        logic [31:0] exp;
        logic [31:0] got;
        found = -1;
        for (int i = 0; i < m_cur; i++) begin
            if (found < 0 && (req_raw & mdl_mask(i)) != 0) found = i;
        end
        exp = (found >= 0) ? mdl_addr(found) : m_def;
        if (found >= 0) begin
            m_saved[found] = m_cur;
            m_cur = found;
        end
        bus_read(A_ACK, got);
        chk(tag, got, exp);
    endtask

    task automatic eoi();
        if (m_cur < 17) m_cur = m_saved[m_cur];
        bus_write(A_ACK, 32'hFFFF_FFFF);
    endtask

    task automatic irq_check(input string tag);
        #1;
        chk(tag, 32'(irq), 32'(|(req_masked & mdl_mask(m_cur))));
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        m_cur = 17;
        m_def = '0;
        for (int i = 0; i < 17; i++) m_saved[i] = 0;
        for (int k = 0; k < 16; k++) begin
            m_ctrl[k] = '0;
            m_vaddr[k] = '0;
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        bus_read(12'h100, d); chk("R1 vaddr0 reset", d, 32'h0);
        bus_read(12'h23C, d); chk("R1 ctrl15 reset", d, 32'h0);
        bus_read(A_DEF, d);   chk("R1 default reset", d, 32'h0);
        set_req(32'h0000_0080);
        chk("R1 idle irq", 32'(irq), 32'd1);
        set_req(32'h0);
        chk("R1 idle no request", 32'(irq), 32'd0);

        // R8: identification bytes
        for (int i = 0; i < 8; i++) begin
            logic [7:0] idb [8];
            idb = '{8'h90, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
            bus_read(12'hFE0 + 12'(4 * i), d);
            chk("R8 id byte", d, 32'(idb[i]));
        end

        // R7: register map, control bytes stored as 8 bits
        m_def = 32'hDEF0_0000;
        bus_write(A_DEF, m_def);
        for (int k = 0; k < 16; k++) begin
            m_vaddr[k] = 32'hA000_0000 + 32'(k) * 32'h111;
            bus_write(12'h100 + 12'(4 * k), m_vaddr[k]);
            write_ctrl(k, 32'h0000_0F00 | 32'h20 | 32'(src_of(k)));
        end
        for (int k = 0; k < 16; k++) begin
            bus_read(12'h100 + 12'(4 * k), d); chk("R7 vaddr readback", d, m_vaddr[k]);
            bus_read(12'h200 + 12'(4 * k), d); chk("R7 ctrl readback", d, 32'(m_ctrl[k]));
        end
        bus_read(A_DEF, d); chk("R7 default readback", d, m_def);

        // R4/R5/R6: sweep every slot as the pending source
        for (int k = 0; k < 16; k++) begin
            set_req(32'd1 << src_of(k));
            ack_check("R4 ack returns next level address");
            irq_check("R3 irq at raised level");
            ack_check("R5 no hit returns default");
            eoi();
            ack_check("R6 restored to idle then ack again");
            eoi();
            set_req(32'h0);
            irq_check("R3 idle quiet");
        end

        // R10: nesting two handlers
        set_req(32'd1 << src_of(5));
        ack_check("R10 outer ack");
        set_req((32'd1 << src_of(5)) | (32'd1 << src_of(2)));
        ack_check("R10 inner ack");
        irq_check("R10 irq at inner level");
        eoi();
        set_req(32'd1 << src_of(5));
        irq_check("R10 irq back at outer level");
        ack_check("R10 outer level blocks own slot");
        eoi();
        ack_check("R10 back at idle");
        eoi();

        // R2: a disabled slot is invisible to the scan
        write_ctrl(9, 32'(src_of(9)));
        set_req(32'd1 << src_of(9));
        ack_check("R2 disabled slot gives default");
        irq_check("R2 idle irq still passes");
        write_ctrl(9, 32'h20 | 32'(src_of(9)));
        ack_check("R2 re-enabled slot acks");
        eoi();

        // R6: end-of-handler write at idle leaves state alone
        set_req(32'h0);
        eoi();
        set_req(32'd1 << src_of(3));
        ack_check("R6 idle write ignored");
        eoi();

        // R9: reconfiguration reaches irq the next cycle
        set_req(32'd1 << src_of(0));
        ack_check("R9 ack slot0");
        irq_check("R9 irq before reconfig");
        write_ctrl(0, 32'h0);
        irq_check("R9 irq after disabling slot0");
        chk("R9 irq low", 32'(irq), 32'd0);
        eoi();
        write_ctrl(0, 32'h20 | 32'(src_of(0)));
        set_req(32'h0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule